// File: doc/BRIEF.md
# Multi-Source Reset Pulse Generator

This block merges several fault indications into a system reset. Five causes feed it: a primary supply fail flag, a secondary supply fail flag, an auxiliary threshold fail flag (all active high, already digitised by comparators elsewhere), an active-low manual-reset request and a one-cycle watchdog expiry pulse. Reset asserts as soon as a cause is seen and is held for a selectable timeout after the last cause has gone away. A cause that comes back during that hold restarts the count from zero.

Three outputs leave the block: an active-low and an active-high reset that are exact complements and answer to every cause, and a second active-low reset that answers only to the two supply flags and the manual request. The hold time is counted in clock-enable ticks; a 3-bit code picks one of eight periods, each a fixed multiple of a parameterised 50 µs tick count. The manual-reset input passes a filter so that short low glitches are dropped. A one-cycle event pulse marks each new assertion of the main reset so that a watchdog can re-arm from it.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `rst_n` is low and out of it, the main reset is asserted (`rst_o`=1) and, with no cause present, releases only after a full selected timeout counted from the first clock after `rst_n` rises.
- R2: A high level on `prim_fail`, `sec_fail`, `aux_fail` or `wd_expire` asserts the main reset on the third rising clock edge after the input changes (two synchronizer stages plus the hold register).
- R3: Once no cause is present, the main reset stays asserted until the count of cycles with `tick_en`=1 reaches the selected period; it then releases on that tick.
- R4: A cause that returns before the timeout has completed restarts the count from zero.
- R5: `mr_n` held low for at least `MR_FILT_CYC` synchronized cycles asserts reset; reset stays asserted for the whole time `mr_n` is low, and the timeout starts only after it returns high.
- R6: A low pulse on `mr_n` shorter than `MR_FILT_CYC` cycles has no effect on any output.
- R7: A single-cycle `wd_expire` pulse produces a main reset that lasts exactly one timeout period (with `tick_en` held high, period cycles).
- R8: `rst2_n_o` responds only to `prim_fail`, `sec_fail` and `mr_n`; `aux_fail` and `wd_expire` leave it high.
- R9: `rst_o` is the exact complement of `rst_n_o` in every cycle.
- R10: `tsel` selects the period in units of `UNIT_TICKS` ticks: 0→33, 1→264, 2→525, 3→1050, 4→4200, 5→8400, 6→16800, 7→33600 units.
- R11: `reset_event` is high for exactly one cycle, the cycle in which the main reset becomes asserted from a released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on init |
| tick_en | input | 1 | Timeout count enable (one tick per unit of time) |
| tsel | input | 3 | Timeout period select code |
| prim_fail | input | 1 | Primary supply under threshold, active high |
| sec_fail | input | 1 | Secondary supply under threshold, active high |
| aux_fail | input | 1 | Auxiliary threshold fail, active high |
| mr_n | input | 1 | Manual reset request, active low |
| wd_expire | input | 1 | Watchdog expiry pulse, active high |
| rst_n_o | output | 1 | Main reset, active low |
| rst_o | output | 1 | Main reset, active high |
| rst2_n_o | output | 1 | Reduced-cause reset, active low |
| reset_event | output | 1 | One-cycle pulse on each new main reset assertion |

## Verification
The embedded assertions watch, on every cycle, that a present cause forces the hold state on the next edge, that the hold counter stays below the period and only releases at its last tick, that nothing releases without a tick, that the reduced reset is never active while the main one is free, and that the event pulse never lasts two cycles. The exact latencies, the glitch threshold of the manual filter, the restart on a returning cause, the period table and the immunity of the reduced output to the auxiliary flag and the watchdog can only be shown by the bench's scenarios, which run a behavioural model alongside the design and measure pulse lengths against the selected periods.

// File: rtl/rpg_pkg.sv
// Shared constants and helpers for the reset pulse generator.
// Assumes the period table is expressed in 50 us units.
package rpg_pkg;
    localparam int unsigned LONGEST_UNITS = 33600;
    localparam int unsigned NUM_CAUSES    = 5;
    // Cause vector bit positions (order is used by the mask parameters)
    localparam int unsigned C_PRIM = 0;
    localparam int unsigned C_SEC  = 1;
    localparam int unsigned C_AUX  = 2;
    localparam int unsigned C_MR   = 3;
    localparam int unsigned C_WD   = 4;

    // Map the select code to a number of 50 us units.
    function automatic int unsigned sel_to_units(input logic [2:0] sel);
        case (sel)
            3'd0:    return 33;
            3'd1:    return 264;
            3'd2:    return 525;
            3'd3:    return 1050;
            3'd4:    return 4200;
            3'd5:    return 8400;
            3'd6:    return 16800;
            default: return 33600;
        endcase
    endfunction
endpackage

// File: rtl/rpg_sync.sv
// Two-flop synchronizer for a bundle of independent level signals.
// Assumes each bit is a slow level; no bus coherency is implied.
module rpg_sync #(
    parameter int unsigned W         = 1,
    parameter logic [W-1:0] INIT_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages, loaded with the idle value at init
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= INIT_VAL;
            q      <= INIT_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rpg_mr_filter.sv
// Manual-reset glitch filter: reports a request only after the
// synchronized input has been low for FILT_CYC consecutive cycles.
// Assumes mr_s is already synchronized; release is immediate-ish.
module rpg_mr_filter #(
    parameter int unsigned FILT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_s,
    output logic mr_req
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_CYC);

    logic [CW-1:0] low_cnt;

    // Count consecutive low cycles, saturating at the filter width
    always_ff @(posedge clk) begin
        if (!rst_n)          low_cnt <= '0;
        else if (mr_s)       low_cnt <= '0;
        else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
    end

    assign mr_req = (low_cnt == FULL);

    AST_MR_FILTER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_req) |-> $past(!mr_s)); // R6
endmodule

// File: rtl/rpg_hold_timer.sv
// Reset hold timer for one output: asserted while a cause is present,
// then held for PERIOD ticks of tick_en before release. A returning
// cause clears the count. Asserted out of init.
module rpg_hold_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cause,
    input  logic [CNT_W-1:0] period,
    output logic             active,
    output logic             assert_evt
);
    logic [CNT_W-1:0] cnt;

    // Hold state and tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (cause) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick_en) begin
            if (cnt >= period - 1'b1) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end
    end

    // Flag a fresh assertion from the released state
    always_ff @(posedge clk) begin
        if (!rst_n) assert_evt <= 1'b0;
        else        assert_evt <= cause && !active;
    end

    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> active); // R2
    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(period) && active |-> cnt < period); // R3
    AST_NO_RELEASE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        active && !tick_en |=> active); // R3
    AST_RESTART_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> cnt == '0); // R4
    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        assert_evt |=> !assert_evt); // R11
endmodule

// File: rtl/rst_pulse_gen.sv
// Multi-source reset pulse generator. Synchronizes five fault causes,
// filters manual reset, and runs one hold timer per output channel,
// each with its own cause mask. Channel 0 drives the main reset pair,
// channel 1 the reduced-cause reset. Assumes tick_en is synchronous.
module rst_pulse_gen
    import rpg_pkg::*;
#(
    parameter int unsigned UNIT_TICKS  = 1,
    parameter int unsigned MR_FILT_CYC = 5,
    parameter logic [NUM_CAUSES-1:0] MAIN_MASK = 5'b11111,
    parameter logic [NUM_CAUSES-1:0] ALT_MASK  = 5'b01011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] tsel,
    input  logic       prim_fail,
    input  logic       sec_fail,
    input  logic       aux_fail,
    input  logic       mr_n,
    input  logic       wd_expire,
    output logic       rst_n_o,
    output logic       rst_o,
    output logic       rst2_n_o,
    output logic       reset_event
);
    localparam int unsigned CNT_W = $clog2(LONGEST_UNITS * UNIT_TICKS + 1);
    localparam int unsigned NCH   = 2;
    localparam logic [NUM_CAUSES-1:0] MASKS [NCH] = '{MAIN_MASK, ALT_MASK};

    logic [3:0]            flags_s;
    logic                  mr_s;
    logic                  mr_req;
    logic [NUM_CAUSES-1:0] causes;
    logic [CNT_W-1:0]      period;
    logic [NCH-1:0]        ch_active;
    logic [NCH-1:0]        ch_evt;

    rpg_sync #(.W(4), .INIT_VAL(4'b0000)) u_flag_sync (
        .clk(clk), .rst_n(rst_n),
        .d({wd_expire, aux_fail, sec_fail, prim_fail}), .q(flags_s));

    rpg_sync #(.W(1), .INIT_VAL(1'b1)) u_mr_sync (
        .clk(clk), .rst_n(rst_n), .d(mr_n), .q(mr_s));

    rpg_mr_filter #(.FILT_CYC(MR_FILT_CYC)) u_mr_filt (
        .clk(clk), .rst_n(rst_n), .mr_s(mr_s), .mr_req(mr_req));

    // Gather the cause vector in package bit order
    always_comb begin
        causes         = '0;
        causes[C_PRIM] = flags_s[0];
        causes[C_SEC]  = flags_s[1];
        causes[C_AUX]  = flags_s[2];
        causes[C_WD]   = flags_s[3];
        causes[C_MR]   = mr_req;
    end

    // Selected hold period in ticks
    always_comb period = CNT_W'(sel_to_units(tsel) * UNIT_TICKS);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        rpg_hold_timer #(.CNT_W(CNT_W)) u_timer (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
            .cause(|(causes & MASKS[ch])), .period(period),
            .active(ch_active[ch]), .assert_evt(ch_evt[ch]));
    end

    assign rst_o       = ch_active[0];
    assign rst_n_o     = ~ch_active[0];
    assign rst2_n_o    = ~ch_active[1];
    assign reset_event = ch_evt[0];

    AST_ALT_WITHIN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !rst2_n_o |-> !rst_n_o); // R8
    AST_MR_HOLDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req |=> rst_o); // R5
    AST_EVENT_ON_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        reset_event |-> rst_o && $past(!rst_o)); // R11
endmodule

// File: tb/test_rst_pulse_gen.sv
// Bench: behavioural reference model checked every cycle plus
// directed scenario checks with measured pulse lengths.
module test_rst_pulse_gen;
    localparam int FILT = 5;

    logic clk = 0, rst_n = 0, tick_en = 1;
    logic [2:0] tsel = 0;
    logic prim_fail = 0, sec_fail = 0, aux_fail = 0, mr_n = 1, wd_expire = 0;
    logic rst_n_o, rst_o, rst2_n_o, reset_event;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rst_pulse_gen #(.UNIT_TICKS(1), .MR_FILT_CYC(FILT)) i_rst_pulse_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tsel(tsel),
        .prim_fail(prim_fail), .sec_fail(sec_fail), .aux_fail(aux_fail),
        .mr_n(mr_n), .wd_expire(wd_expire), .rst_n_o(rst_n_o), .rst_o(rst_o),
        .rst2_n_o(rst2_n_o), .reset_event(reset_event));

    function automatic int units(input int s);
        int tbl[8] = '{33, 264, 525, 1050, 4200, 8400, 16800, 33600};
        return tbl[s];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: input history queue, filter count, two hold counters
    logic [4:0] hist[$];
    int lowc, m_cnt[2];
    bit m_act[2], m_evt;

    always @(posedge clk) begin
        logic [4:0] seen;
        bit c[2], mreq;
        if (!rst_n) begin
            hist = '{5'b01000, 5'b01000};
            lowc = 0; m_act = '{1, 1}; m_cnt = '{0, 0}; m_evt = 0;
        end else begin
            seen = hist.pop_front();            // value two edges old: {wd,mr_n,aux,sec,prim}
            mreq = (lowc == FILT);
            c[0] = seen[0] | seen[1] | seen[2] | seen[4] | mreq;
            c[1] = seen[0] | seen[1] | mreq;
            m_evt = c[0] && !m_act[0];
            for (int k = 0; k < 2; k++) begin
                if (c[k]) begin m_act[k] = 1; m_cnt[k] = 0; end
                else if (m_act[k] && tick_en) begin
                    m_cnt[k]++;
                    if (m_cnt[k] >= units(tsel)) begin m_act[k] = 0; m_cnt[k] = 0; end
                end
            end
            if (seen[3]) lowc = 0; else if (lowc < FILT) lowc++;
            hist.push_back({wd_expire, mr_n, aux_fail, sec_fail, prim_fail});
        end
    end

    always @(negedge clk) if (!done) begin
        check(rst_n_o == !m_act[0], "R3 rst_n_o model", rst_n_o, !m_act[0]);
        check(rst2_n_o == !m_act[1], "R8 rst2_n_o model", rst2_n_o, !m_act[1]);
        check(reset_event == m_evt, "R11 reset_event model", reset_event, m_evt);
        check(rst_o == !rst_n_o, "R9 complement", rst_o, !rst_n_o);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (rst_o || !rst2_n_o) @(negedge clk);
        cyc(2);
    endtask

    // Pulse the watchdog once and measure the main reset width
    task automatic wd_width(input int s, output int w, output int evs);
        tsel = 3'(s); wait_idle();
        wd_expire = 1; cyc(1); wd_expire = 0;
        w = 0; evs = 0;
        while (!rst_o) begin evs += reset_event; @(negedge clk); end
        while (rst_o) begin w++; evs += reset_event; @(negedge clk); end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w, evs;
        cyc(3);
        check(rst_o == 1 && rst_n_o == 0 && rst2_n_o == 0, "R1 init asserted", rst_o, 1);
        rst_n = 1;
        cyc(20);
        check(rst_o == 1, "R1 held after init", rst_o, 1);
        wait_idle();

        // R2 latency on primary flag
        prim_fail = 1; cyc(2);
        check(rst_o == 0, "R2 not before third edge", rst_o, 0);
        cyc(1);
        check(rst_o == 1 && rst2_n_o == 0, "R2 prim asserts", rst_o, 1);
        cyc(5); prim_fail = 0;

        // R4 restart with secondary returning
        wait_idle();
        sec_fail = 1; cyc(4); sec_fail = 0;
        cyc(25); sec_fail = 1; cyc(2); sec_fail = 0; cyc(25);
        check(rst_o == 1, "R4 restart extends hold", rst_o, 1);
        check(rst2_n_o == 0, "R4 reduced output restarted", rst2_n_o, 0);

        // R8 auxiliary and watchdog do not touch reduced output
        wait_idle();
        aux_fail = 1; cyc(6);
        check(rst_o == 1 && rst2_n_o == 1, "R8 aux ignored by rst2", rst2_n_o, 1);
        aux_fail = 0;
        wait_idle();
        wd_expire = 1; cyc(1); wd_expire = 0; cyc(5);
        check(rst_o == 1 && rst2_n_o == 1, "R8 wd ignored by rst2", rst2_n_o, 1);

        // R6 short manual pulse ignored
        wait_idle();
        mr_n = 0; cyc(FILT - 1); mr_n = 1;
        begin
            int seen_hi = 0;
            for (int i = 0; i < 12; i++) begin seen_hi |= rst_o | !rst2_n_o; cyc(1); end
            check(seen_hi == 0, "R6 short mr pulse ignored", seen_hi, 0);
        end

        // R5 long manual hold
        mr_n = 0; cyc(60);
        check(rst_o == 1 && rst2_n_o == 0, "R5 held while mr low", rst_o, 1);
        mr_n = 1; cyc(25);
        check(rst_o == 1, "R5 timeout starts after release", rst_o, 1);

        // R7/R10/R11 widths per code
        wd_width(0, w, evs);
        check(w == 33, "R7 wd width code0", w, 33);
        check(evs == 1, "R11 one event", evs, 1);
        wd_width(1, w, evs);
        check(w == 264, "R10 code1 width", w, 264);
        wd_width(2, w, evs);
        check(w == 525, "R10 code2 width", w, 525);
        wd_width(3, w, evs);
        check(w == 1050, "R10 code3 width", w, 1050);
        wd_width(4, w, evs);
        check(w == 4200, "R10 code4 width", w, 4200);

        // R3 gapped ticks
        tsel = 0; wait_idle();
        fork
            begin while (!done) begin tick_en = 1; cyc(1); tick_en = 0; cyc(2); end end
            begin
                wd_expire = 1; cyc(1); wd_expire = 0;
                while (!rst_o) cyc(1);
                w = 0;
                while (rst_o) begin w++; cyc(1); end
                check(w >= 97 && w <= 101, "R3 width with 1-in-3 ticks", w, 99);
                cyc(5);
                done = 1;
            end
        join
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule